// File: doc/BRIEF.md
# Byte-to-Word Disk Register Bridge

This block connects an 8-bit host I/O port bus to a 16-bit disk task-file register set. The host side has a port address, one byte of write data, one byte of read data and two level strobes, OUT and IN. The disk side has three register-index lines, two active-low register-bank selects, active-low read and write strobes and a 16-bit data path. The block answers a window of sixteen host ports. The low eight ports map to bank 0 registers 0 to 7, and the high eight ports map to bank 1 registers 0 to 7. The 16-bit data register is bank 0, index 0.

Control and status registers move one byte per host access. A host write is run as a disk write cycle once the OUT strobe has ended. A host read passes straight through to the disk bus while the IN strobe is high. Data-register traffic is packed two host bytes to one disk word. An internal sequencer runs each disk word cycle, and it only starts after the host strobe that asked for it has ended. Host reads are fetched ahead, one word at a time, within a sector of `SECT_WORDS` words.

The host strobes cannot be stalled, so there is no back-pressure path. The host has to pace itself by watching `busy`. Any access the block has to drop while busy is recorded in a sticky `overrun` flag.

Top module: `byte_word_bridge`

## Requirements
- R1: Only host ports whose address bits above bit 3 equal those of `BASE_ADDR` are decoded. An OUT or IN outside that window starts no disk cycle and returns 0x00 on `h_rdata`.
- R2: Host write data and address are taken from the last clock on which OUT was high. The disk write strobe first goes low one setup clock after the clock on which OUT is first seen low.
- R3: On the data register (bank 0, index 0), the first OUT of a pair supplies the low byte and the second supplies the high byte. The second OUT starts one disk write with the high byte on `dev_wdata[15:8]` and the low byte on `dev_wdata[7:0]`.
- R4: A data-register read takes both bytes in one disk read. IN then returns the low byte first and the high byte second, and only after that read has finished. While no word is held, IN returns 0x00.
- R5: An IN to the data register that finds no word held and the pair flag on the low byte starts a fetch. After the host takes the high byte, the next word is fetched automatically. At most `SECT_WORDS` words (default 256, that is 512 host bytes) are fetched before a non-data register write reloads the count. Once the count is used up, further INs start no disk read.
- R6: An OUT to any register other than the data register runs one disk write with the byte on `dev_wdata[7:0]` and zeros above. It also returns the pair flag to the low byte, discards any held read word and reloads the sector count.
- R7: An IN to a register other than the data register, with the block idle, drives `dev_rd_n` low, selects the matching bank and index combinationally, and returns `dev_rdata[7:0]` on `h_rdata`.
- R8: A sequenced disk strobe stays low for exactly `STROBE_CLKS` clocks. Bank select and index are valid one clock before the strobe falls and one clock after it rises. `dev_wdata_en` covers the whole write cycle, and `dev_wdata` does not change while the write strobe is low.
- R9: `busy` is high for exactly `STROBE_CLKS`+2 clocks from the clock after a cycle is requested. An OUT, or a data-register IN, that ends while busy is ignored and sets `overrun`, which stays set until reset. A non-data IN while busy returns 0x00 and does not strobe the disk.
- R10: Synchronous active-high `rst` leaves both disk strobes and both selects high, `busy` and `overrun` low, the pair flag on the low byte and no read word held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| h_addr | input | HADDR_W | Host port address |
| h_wdata | input | 8 | Host write byte |
| h_rdata | output | 8 | Host read byte, valid while IN is high |
| h_out | input | 1 | Host OUT strobe, active high |
| h_in | input | 1 | Host IN strobe, active high |
| busy | output | 1 | Disk cycle in progress |
| overrun | output | 1 | Sticky: a host access was dropped while busy |
| dev_addr | output | 3 | Disk register index |
| dev_sel0_n | output | 1 | Bank 0 select, active low |
| dev_sel1_n | output | 1 | Bank 1 select, active low |
| dev_rd_n | output | 1 | Disk read strobe, active low |
| dev_wr_n | output | 1 | Disk write strobe, active low |
| dev_wdata | output | 16 | Disk write word |
| dev_wdata_en | output | 1 | Drive enable for `dev_wdata` |
| dev_rdata | input | 16 | Disk read word |

## Verification
The bench goes after four corner cases.

- **Byte order inside a pair.** It writes several pairs and reads a full sector of distinct words. A swapped lane or a flag that toggles on the wrong access shows up as mismatched bytes.
- **Fetch count at the sector boundary.** It reads one byte past the end of the sector. A design that counts wrong either strobes the disk once too often or returns stale data.
- **Interaction between register types.** A non-data write lands between the two halves of a pair, and a status read is issued while a word cycle runs. A design that does not clear the flag packs the wrong bytes. A design that does not gate the pass-through strobes the disk in the middle of a cycle.
- **Access during busy.** A third data OUT lands inside a running cycle. A design without the busy guard corrupts the next word or misses the overrun flag.

// File: rtl/bwb_pkg.sv
package bwb_pkg;

  localparam logic [2:0] DATA_IDX = 3'd0;

  typedef struct packed {
    logic        cs1;
    logic [2:0]  idx;
    logic        wr;
    logic [15:0] data;
  } dev_req_t;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_SETUP,
    SQ_STRB,
    SQ_HOLD
  } seq_st_t;

endpackage

// File: rtl/bwb_host_decode.sv
module bwb_host_decode #(
  parameter int HADDR_W = 8,
  parameter logic [HADDR_W-1:0] BASE_ADDR = 'h30
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [HADDR_W-1:0] h_addr,
  input  logic [7:0]         h_wdata,
  input  logic               h_out,
  input  logic               h_in,
  output logic               cur_hit,
  output logic               cur_cs1,
  output logic [2:0]         cur_idx,
  output logic               out_evt,
  output logic               in_evt,
  output logic               evt_cs1,
  output logic [2:0]         evt_idx,
  output logic [7:0]         evt_data
);
  localparam int WIN_LSB = 4;

  logic               out_q, in_q;
  logic [HADDR_W-1:0] addr_q;
  logic [7:0]         data_q;
  logic               hit_q;

  // strobe level and qualifiers from the previous clock; the event fires on the first low clock
  always_ff @(posedge clk) begin
    if (rst) begin
      out_q  <= 1'b0;
      in_q   <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      out_q  <= h_out;
      in_q   <= h_in;
      addr_q <= h_addr;
      data_q <= h_wdata;
    end
  end

  assign cur_hit  = (h_addr[HADDR_W-1:WIN_LSB] == BASE_ADDR[HADDR_W-1:WIN_LSB]);
  assign hit_q    = (addr_q[HADDR_W-1:WIN_LSB] == BASE_ADDR[HADDR_W-1:WIN_LSB]);
  assign cur_cs1  = h_addr[3];
  assign cur_idx  = h_addr[2:0];
  assign out_evt  = out_q & ~h_out & hit_q;
  assign in_evt   = in_q & ~h_in & hit_q;
  assign evt_cs1  = addr_q[3];
  assign evt_idx  = addr_q[2:0];
  assign evt_data = data_q;

endmodule

// File: rtl/bwb_pair_ctl.sv
module bwb_pair_ctl
  import bwb_pkg::*;
#(
  parameter int SECT_WORDS = 256
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       out_evt,
  input  logic       in_evt,
  input  logic       evt_cs1,
  input  logic [2:0] evt_idx,
  input  logic [7:0] evt_data,
  input  logic       busy,
  input  logic       done_rd,
  output logic       start,
  output dev_req_t   req,
  output logic       tog,
  output logic       rv,
  output logic       overrun
);
  localparam int WW = $clog2(SECT_WORDS + 1);

  logic [7:0]    lo_byte;
  logic [WW-1:0] wrem;
  logic          is_data;
  logic          want_rd;

  assign is_data = !evt_cs1 && (evt_idx == DATA_IDX);
  assign want_rd = in_evt && is_data && !busy && (wrem != '0) &&
                   ((!rv && !tog) || (rv && tog));

  always_comb begin
    start = 1'b0;
    req   = '0;
    if (out_evt && !busy) begin
      if (!is_data) begin
        start = 1'b1;
        req   = '{cs1: evt_cs1, idx: evt_idx, wr: 1'b1, data: {8'h00, evt_data}};
      end else if (tog) begin
        start = 1'b1;
        req   = '{cs1: 1'b0, idx: DATA_IDX, wr: 1'b1, data: {evt_data, lo_byte}};
      end
    end else if (want_rd) begin
      start = 1'b1;
      req   = '{cs1: 1'b0, idx: DATA_IDX, wr: 1'b0, data: 16'h0000};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tog     <= 1'b0;
      lo_byte <= '0;
      rv      <= 1'b0;
      wrem    <= WW'(SECT_WORDS);
      overrun <= 1'b0;
    end else begin
      if (done_rd) rv <= 1'b1;
      if (out_evt) begin
        if (busy) overrun <= 1'b1;
        else if (is_data) begin
          if (!tog) lo_byte <= evt_data;
          tog <= ~tog;
        end else begin
          tog  <= 1'b0;
          rv   <= 1'b0;
          wrem <= WW'(SECT_WORDS);
        end
      end else if (in_evt && is_data) begin
        if (busy) overrun <= 1'b1;
        else if (rv) begin
          tog <= ~tog;
          if (tog) rv <= 1'b0;
        end
        if (want_rd) wrem <= wrem - 1'b1;
      end
    end
  end

endmodule

// File: rtl/bwb_dev_seq.sv
module bwb_dev_seq
  import bwb_pkg::*;
#(
  parameter int STROBE_CLKS = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  dev_req_t    req,
  input  logic [15:0] dev_rdata,
  output logic        busy,
  output logic        done_rd,
  output logic        s_cs1,
  output logic [2:0]  s_idx,
  output logic        s_rd,
  output logic        s_wr,
  output logic [15:0] s_wdata,
  output logic        s_wdata_en,
  output logic [15:0] rword
);
  localparam int CW = $clog2(STROBE_CLKS + 1);
  localparam logic [CW-1:0] LAST = CW'(STROBE_CLKS - 1);

  seq_st_t       st;
  logic [CW-1:0] cnt;
  dev_req_t      cur;

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= SQ_IDLE;
      cnt   <= '0;
      cur   <= '0;
      rword <= '0;
    end else begin
      case (st)
        SQ_IDLE: if (start) begin
          cur <= req;
          st  <= SQ_SETUP;
        end
        SQ_SETUP: begin
          cnt <= '0;
          st  <= SQ_STRB;
        end
        SQ_STRB: begin
          if (cnt == LAST) begin
            if (!cur.wr) rword <= dev_rdata;
            st <= SQ_HOLD;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        SQ_HOLD: st <= SQ_IDLE;
        default: st <= SQ_IDLE;
      endcase
    end
  end

  assign busy       = (st != SQ_IDLE);
  assign s_rd       = (st == SQ_STRB) && !cur.wr;
  assign s_wr       = (st == SQ_STRB) && cur.wr;
  assign done_rd    = (st == SQ_HOLD) && !cur.wr;
  assign s_cs1      = cur.cs1;
  assign s_idx      = cur.idx;
  assign s_wdata    = cur.data;
  assign s_wdata_en = busy && cur.wr;

endmodule

// File: rtl/byte_word_bridge.sv
module byte_word_bridge
  import bwb_pkg::*;
#(
  parameter int HADDR_W = 8,
  parameter logic [HADDR_W-1:0] BASE_ADDR = 'h30,
  parameter int STROBE_CLKS = 4,
  parameter int SECT_WORDS = 256
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [HADDR_W-1:0] h_addr,
  input  logic [7:0]         h_wdata,
  output logic [7:0]         h_rdata,
  input  logic               h_out,
  input  logic               h_in,
  output logic               busy,
  output logic               overrun,
  output logic [2:0]         dev_addr,
  output logic               dev_sel0_n,
  output logic               dev_sel1_n,
  output logic               dev_rd_n,
  output logic               dev_wr_n,
  output logic [15:0]        dev_wdata,
  output logic               dev_wdata_en,
  input  logic [15:0]        dev_rdata
);
  logic       cur_hit, cur_cs1;
  logic [2:0] cur_idx;
  logic       out_evt, in_evt, evt_cs1;
  logic [2:0] evt_idx;
  logic [7:0] evt_data;
  logic       start, tog, rv, done_rd;
  dev_req_t   req;
  logic       s_cs1, s_rd, s_wr;
  logic [2:0] s_idx;
  logic [15:0] rword;
  logic       cur_data, pass;

  bwb_host_decode #(.HADDR_W(HADDR_W), .BASE_ADDR(BASE_ADDR)) u_dec (
    .clk(clk), .rst(rst), .h_addr(h_addr), .h_wdata(h_wdata),
    .h_out(h_out), .h_in(h_in), .cur_hit(cur_hit), .cur_cs1(cur_cs1),
    .cur_idx(cur_idx), .out_evt(out_evt), .in_evt(in_evt),
    .evt_cs1(evt_cs1), .evt_idx(evt_idx), .evt_data(evt_data)
  );

  bwb_pair_ctl #(.SECT_WORDS(SECT_WORDS)) u_pair (
    .clk(clk), .rst(rst), .out_evt(out_evt), .in_evt(in_evt),
    .evt_cs1(evt_cs1), .evt_idx(evt_idx), .evt_data(evt_data),
    .busy(busy), .done_rd(done_rd), .start(start), .req(req),
    .tog(tog), .rv(rv), .overrun(overrun)
  );

  bwb_dev_seq #(.STROBE_CLKS(STROBE_CLKS)) u_seq (
    .clk(clk), .rst(rst), .start(start), .req(req), .dev_rdata(dev_rdata),
    .busy(busy), .done_rd(done_rd), .s_cs1(s_cs1), .s_idx(s_idx),
    .s_rd(s_rd), .s_wr(s_wr), .s_wdata(dev_wdata),
    .s_wdata_en(dev_wdata_en), .rword(rword)
  );

  // single-byte register reads bypass the sequencer while it is idle
  assign cur_data = !cur_cs1 && (cur_idx == DATA_IDX);
  assign pass     = h_in && cur_hit && !cur_data && !busy;

  assign dev_addr   = busy ? s_idx : cur_idx;
  assign dev_sel0_n = ~((busy && !s_cs1) || (pass && !cur_cs1));
  assign dev_sel1_n = ~((busy && s_cs1) || (pass && cur_cs1));
  assign dev_rd_n   = ~(s_rd || pass);
  assign dev_wr_n   = ~s_wr;

  always_comb begin
    h_rdata = 8'h00;
    if (h_in && cur_hit && !busy) begin
      if (!cur_data)  h_rdata = dev_rdata[7:0];
      else if (rv)    h_rdata = tog ? rword[15:8] : rword[7:0];
    end
  end

endmodule

// File: rtl/byte_word_bridge_chk.sv
module byte_word_bridge_chk #(
  parameter int STROBE_CLKS = 4
) (
  input logic        clk,
  input logic        rst,
  input logic        dev_rd_n,
  input logic        dev_wr_n,
  input logic        dev_sel0_n,
  input logic        dev_sel1_n,
  input logic [15:0] dev_wdata,
  input logic        dev_wdata_en,
  input logic        busy,
  input logic        overrun
);
  logic [7:0] wr_run;

  always_ff @(posedge clk) begin
    if (rst) wr_run <= '0;
    else if (!dev_wr_n) wr_run <= wr_run + 8'd1;
    else wr_run <= '0;
  end

  a_r8_strobe_len: assert property (@(posedge clk) disable iff (rst)
    $rose(dev_wr_n) |-> (wr_run == 8'(STROBE_CLKS)));

  a_r8_sel_setup: assert property (@(posedge clk) disable iff (rst)
    $fell(dev_wr_n) |-> $past(!dev_sel0_n || !dev_sel1_n));

  a_r8_sel_hold: assert property (@(posedge clk) disable iff (rst)
    $rose(dev_wr_n) |-> (!dev_sel0_n || !dev_sel1_n));

  a_r8_wdata_stable: assert property (@(posedge clk) disable iff (rst)
    !dev_wr_n |-> ($stable(dev_wdata) && dev_wdata_en));

  a_r8_no_both_strobes: assert property (@(posedge clk) disable iff (rst)
    !(!dev_rd_n && !dev_wr_n));

  a_r9_wr_only_busy: assert property (@(posedge clk) disable iff (rst)
    !dev_wr_n |-> busy);

  a_r9_overrun_sticky: assert property (@(posedge clk) disable iff (rst)
    overrun |=> overrun);

  a_r10_reset_idle: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (dev_rd_n && dev_wr_n && !busy && !overrun));

endmodule

bind byte_word_bridge byte_word_bridge_chk #(.STROBE_CLKS(STROBE_CLKS)) u_chk (
  .clk(clk), .rst(rst), .dev_rd_n(dev_rd_n), .dev_wr_n(dev_wr_n),
  .dev_sel0_n(dev_sel0_n), .dev_sel1_n(dev_sel1_n), .dev_wdata(dev_wdata),
  .dev_wdata_en(dev_wdata_en), .busy(busy), .overrun(overrun)
);

// File: tb/test_byte_word_bridge.sv
module test_byte_word_bridge;
  localparam int S = 4;
  localparam int SW = 256;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  h_addr = 8'h00;
  logic [7:0]  h_wdata = 8'h00;
  logic        h_out = 1'b0;
  logic        h_in = 1'b0;
  logic [7:0]  h_rdata;
  logic        busy, overrun;
  logic [2:0]  dev_addr;
  logic        dev_sel0_n, dev_sel1_n, dev_rd_n, dev_wr_n, dev_wdata_en;
  logic [15:0] dev_wdata, dev_rdata;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  byte_word_bridge i_byte_word_bridge (
    .clk(clk), .rst(rst), .h_addr(h_addr), .h_wdata(h_wdata), .h_rdata(h_rdata),
    .h_out(h_out), .h_in(h_in), .busy(busy), .overrun(overrun),
    .dev_addr(dev_addr), .dev_sel0_n(dev_sel0_n), .dev_sel1_n(dev_sel1_n),
    .dev_rd_n(dev_rd_n), .dev_wr_n(dev_wr_n), .dev_wdata(dev_wdata),
    .dev_wdata_en(dev_wdata_en), .dev_rdata(dev_rdata)
  );

  function automatic logic [15:0] fw(int k);
    fw = {8'(k * 3 + 1), 8'(k * 7 + 2)};
  endfunction

  function automatic bit in_win(logic [7:0] a);
    in_win = (a[7:4] == 4'h3);
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // disk register model
  logic [7:0] dregs [16];
  int didx = 0;
  logic prev_rdn = 1'b1, prev_wrn = 1'b1, prev_s0 = 1'b1, prev_s1 = 1'b1;
  logic [2:0] prev_a = 3'd0;
  logic [15:0] prev_wd = 16'h0;

  initial for (int i = 0; i < 16; i++) dregs[i] = 8'(i * 17 + 3);

  always_comb begin
    if (!dev_sel0_n && dev_addr == 3'd0) dev_rdata = fw(didx);
    else dev_rdata = {8'h00, dregs[{!dev_sel1_n, dev_addr}]};
  end

  // behavioural reference
  int m_cnt = 0;
  bit m_isrd = 0, m_tog = 0, m_rv = 0, m_ovr = 0;
  logic [7:0] m_lo = 0;
  logic [15:0] m_word = 0;
  int m_wrem = SW;
  int m_rdn = 0;
  logic [19:0] m_wq[$];
  bit m_oq = 0, m_iq = 0;
  logic [7:0] m_aq = 0, m_dq = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_isrd = 0; m_tog = 0; m_rv = 0; m_ovr = 0; m_lo = 0;
      m_word = 0; m_wrem = SW; m_wq.delete();
      m_oq = 0; m_iq = 0; m_aq = 0; m_dq = 0;
    end else begin
      bit bsy, fetch;
      bsy = (m_cnt > 0);
      if (m_cnt == 1 && m_isrd) begin m_rv = 1; m_word = fw(m_rdn); m_rdn++; end
      if (m_cnt > 0) m_cnt--;
      if (m_oq && !h_out && in_win(m_aq)) begin
        if (bsy) m_ovr = 1;
        else if (m_aq[3:0] == 4'h0) begin
          if (m_tog) begin
            m_wq.push_back({1'b0, 3'd0, m_dq, m_lo}); m_cnt = S + 2; m_isrd = 0;
          end else m_lo = m_dq;
          m_tog = !m_tog;
        end else begin
          m_wq.push_back({m_aq[3], m_aq[2:0], 8'h00, m_dq}); m_cnt = S + 2; m_isrd = 0;
          m_tog = 0; m_rv = 0; m_wrem = SW;
        end
      end else if (m_iq && !h_in && in_win(m_aq) && m_aq[3:0] == 4'h0) begin
        if (bsy) m_ovr = 1;
        else begin
          fetch = 0;
          if (!m_rv && !m_tog) fetch = (m_wrem > 0);
          else if (m_rv) begin
            if (m_tog) begin m_rv = 0; fetch = (m_wrem > 0); end
            m_tog = !m_tog;
          end
          if (fetch) begin m_cnt = S + 2; m_isrd = 1; m_wrem--; end
        end
      end
      m_oq = h_out; m_iq = h_in; m_aq = h_addr; m_dq = h_wdata;
    end
  end

  // per-clock comparison and disk-side transaction capture, away from the edge
  always @(negedge clk) begin
    if (!rst) begin
      bit pass, strb;
      logic [7:0] eh;
      logic [19:0] ew;
      strb = (m_cnt >= 2 && m_cnt <= S + 1);
      pass = h_in && in_win(h_addr) && h_addr[3:0] != 4'h0 && m_cnt == 0;
      eh = 8'h00;
      if (h_in && in_win(h_addr) && m_cnt == 0) begin
        if (h_addr[3:0] != 4'h0) eh = dregs[h_addr[3:0]];
        else if (m_rv) eh = m_tog ? m_word[15:8] : m_word[7:0];
      end
      chk(busy == (m_cnt > 0), "R9 busy", busy, m_cnt > 0);
      chk(overrun == m_ovr, "R9 overrun", overrun, m_ovr);
      chk(dev_wr_n == !(strb && !m_isrd), "R8 write strobe", dev_wr_n, !(strb && !m_isrd));
      chk(dev_rd_n == !((strb && m_isrd) || pass), "R7 R8 read strobe", dev_rd_n,
          !((strb && m_isrd) || pass));
      chk(h_rdata == eh, "R4 R7 host read byte", h_rdata, eh);
      if (!prev_wrn && dev_wr_n) begin
        if (m_wq.size() == 0) chk(0, "R3 R6 unexpected disk write", dev_wdata, 0);
        else begin
          ew = m_wq.pop_front();
          chk({!prev_s1, prev_a, prev_wd} == ew, "R3 R6 disk write", {!prev_s1, prev_a, prev_wd}, ew);
        end
        if (!(prev_s0 == 1'b0 && prev_a == 3'd0)) dregs[{!prev_s1, prev_a}] = prev_wd[7:0];
      end
      if (!prev_rdn && dev_rd_n && !dev_sel0_n && dev_addr == 3'd0) didx++;
    end
    prev_rdn = dev_rd_n; prev_wrn = dev_wr_n; prev_s0 = dev_sel0_n;
    prev_s1 = dev_sel1_n; prev_a = dev_addr; prev_wd = dev_wdata;
  end

  task automatic host_out(logic [7:0] a, logic [7:0] d, int gap);
    @(posedge clk); #1;
    h_addr = a; h_wdata = d; h_out = 1'b1;
    repeat (3) @(posedge clk);
    #1 h_out = 1'b0;
    repeat (gap) @(posedge clk);
  endtask

  task automatic host_in(logic [7:0] a, output logic [7:0] v, input int gap);
    @(posedge clk); #1;
    h_addr = a; h_in = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk) v = h_rdata;
    @(posedge clk); #1 h_in = 1'b0;
    repeat (gap) @(posedge clk);
  endtask

  task automatic check_reset_state(string tag);
    @(negedge clk);
    chk(dev_rd_n && dev_wr_n && dev_sel0_n && dev_sel1_n, tag,
        {dev_rd_n, dev_wr_n, dev_sel0_n, dev_sel1_n}, 4'hF);
    chk(!busy && !overrun, tag, {busy, overrun}, 0);
  endtask

  initial begin
    logic [7:0] v;
    repeat (5) @(posedge clk);
    #1 rst = 1'b0;
    check_reset_state("R10 reset state");

    // R1: outside the window
    host_out(8'h20, 8'hAA, 8);
    host_in(8'h47, v, 4);
    chk(v == 8'h00, "R1 out-of-window read", v, 0);

    // R6, R2: single-byte writes to both banks
    host_out(8'h32, 8'h55, 8);
    host_out(8'h3E, 8'h0A, 8);
    // R7: pass-through read
    host_in(8'h32, v, 4);
    chk(v == 8'h55, "R7 status pass-through", v, 8'h55);
    host_in(8'h3E, v, 4);
    chk(v == 8'h0A, "R7 bank 1 pass-through", v, 8'h0A);

    // R3: word pairs
    host_out(8'h30, 8'h34, 2); host_out(8'h30, 8'h12, 8);
    host_out(8'h30, 8'hCD, 2); host_out(8'h30, 8'hAB, 8);
    // R6: non-data write between halves restarts the pair
    host_out(8'h30, 8'hEE, 2); host_out(8'h33, 8'h01, 8);
    host_out(8'h30, 8'h78, 2); host_out(8'h30, 8'h56, 8);

    // R4, R5: full sector read
    host_out(8'h37, 8'h20, 8);
    host_in(8'h30, v, 10);
    chk(v == 8'h00, "R5 priming read returns zero", v, 0);
    for (int k = 0; k < SW; k++) begin
      logic [15:0] w;
      w = fw(k);
      host_in(8'h30, v, 2);
      chk(v == w[7:0], "R4 low byte first", v, w[7:0]);
      host_in(8'h30, v, 10);
      chk(v == w[15:8], "R4 high byte second", v, w[15:8]);
    end
    host_in(8'h30, v, 10);
    chk(v == 8'h00, "R5 no fetch past sector end", v, 0);
    chk(didx == SW, "R5 disk read count", didx, SW);

    // R9: status read while busy
    host_out(8'h30, 8'h66, 2); host_out(8'h30, 8'h77, 0);
    host_in(8'h32, v, 8);
    chk(v == 8'h00, "R9 read while busy returns zero", v, 0);
    chk(!overrun, "R9 no overrun yet", overrun, 0);

    // R9: OUT during busy is dropped
    host_out(8'h30, 8'h11, 2); host_out(8'h30, 8'h22, 0);
    host_out(8'h30, 8'h33, 8);
    @(negedge clk);
    chk(overrun, "R9 overrun set", overrun, 1);
    host_out(8'h30, 8'h44, 2); host_out(8'h30, 8'h55, 8);

    // R10: reset in the middle of a cycle
    host_out(8'h30, 8'h99, 2); host_out(8'h30, 8'h88, 0);
    repeat (2) @(posedge clk);
    #1 rst = 1'b1;
    repeat (2) @(posedge clk);
    #1 rst = 1'b0;
    check_reset_state("R10 reset mid-cycle");
    host_in(8'h30, v, 10);
    chk(v == 8'h00, "R10 no word held after reset", v, 0);
    repeat (4) @(posedge clk);
    chk(m_wq.size() == 0, "R3 R6 all writes seen", m_wq.size(), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule